// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block turns an asynchronous serial line into parallel characters. A tick enable, pulsed at sixteen times the bit rate, paces all sampling. The receiver waits for the line to rest high. It then treats a falling edge as a possible start bit and confirms it by a vote over three early samples. Every later bit is decided by a vote over three samples at the middle of the bit. A character carries 8 or 9 data bits, least significant first. An optional parity bit may follow the data, and one stop bit ends the character.

A finished character is placed in a single holding register and offered on a valid/ready output. The holding register also carries the frame error and parity error that belong to that character. Back-pressure works as follows. While `rd_valid` is high and `rd_ready` is low, the character and its flags stay unchanged. A transfer happens on any clock edge where both are high. A character that completes while the register is still full, and is not read in that same cycle, is dropped. The character already held is kept, and a sticky overrun flag is raised. Configuration inputs are expected to change only while the line is idle.

Top module: `ovs_uart_rx`

## Requirements
- R1: After reset `rd_valid`, `rd_frame_err`, `rd_par_err` and `rd_overrun` are 0.
- R2: A falling edge begins a start bit only when at least three consecutive high samples directly precede it. A low sample seen with fewer highs before it is ignored, and no character results.
- R3: Counting the first low sample as sample 1, the samples numbered 3, 5 and 7 are voted. If two or more are low, reception continues. Otherwise the receiver returns to waiting for idle, and no character is produced.
- R4: Each data, parity and stop bit takes the majority value of its samples 8, 9 and 10. The other 13 samples of the bit have no effect.
- R5: Data arrives least significant bit first. With `cfg_nine`=0, `rd_data` holds the 8 bits and `rd_bit8` is 0. With `cfg_nine`=1, the ninth received bit appears on `rd_bit8`.
- R6: `rd_valid` rises on the tick that decides the stop bit. While `rd_valid`=1 and `rd_ready`=0, `rd_valid`, `rd_data`, `rd_bit8` and both error flags hold their values.
- R7: `rd_frame_err` is 1 with a character whose stop bit was decided low. The data is still delivered.
- R8: With `cfg_par_en`=1, one parity bit follows the data bits. `rd_par_err` is 1 when that bit differs from the XOR of the data bits XOR `cfg_par_odd` (0 = even, 1 = odd).
- R9: When a character completes while `rd_valid`=1 and `rd_ready`=0, the new character is discarded, the held one is kept, and `rd_overrun` goes to 1.
- R10: A transfer (`rd_valid` and `rd_ready` both 1 at a clock edge) clears `rd_valid`, `rd_frame_err`, `rd_par_err` and `rd_overrun` on that edge, unless a new character is accepted on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_16x | input | 1 | Sample enable at 16x the bit rate |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| cfg_nine | input | 1 | 1 selects 9 data bits |
| cfg_par_en | input | 1 | 1 adds a parity bit after the data |
| cfg_par_odd | input | 1 | Parity sense, 1 = odd |
| rd_ready | input | 1 | Consumer accepts the held character |
| rd_valid | output | 1 | Holding register full |
| rd_data | output | 8 | Low 8 data bits |
| rd_bit8 | output | 1 | Ninth data bit, 0 in 8-bit mode |
| rd_frame_err | output | 1 | Stop bit was low for this character |
| rd_par_err | output | 1 | Parity mismatch for this character |
| rd_overrun | output | 1 | A character was dropped while full |

## Verification
Several rules are checked on every cycle. The held character must stay stable under back-pressure. Error and overrun flags may appear only while a character is held. `rd_valid` may rise only on a sample tick. A transfer must clear the overrun flag. Other behaviour can only be shown by driving chosen sample patterns, and the bench covers it. This includes which sample positions drive the start vote and the bit votes, rejection of an unarmed falling edge, bit order, parity sense, and which character survives an overrun.

// File: rtl/urx_pkg.sv
package urx_pkg;
  typedef enum logic [1:0] {
    URX_HUNT  = 2'd0,
    URX_START = 2'd1,
    URX_BITS  = 2'd2
  } urx_state_e;
endpackage

// File: rtl/urx_sync.sv
module urx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/urx_vote3.sv
module urx_vote3 (
  input  logic a,
  input  logic b,
  input  logic c,
  output logic m
);
  assign m = (a & b) | (a & c) | (b & c);
endmodule

// File: rtl/urx_framer.sv
module urx_framer
  import urx_pkg::*;
#(
  parameter int OVS      = 16,
  parameter int DATA_W   = 8,
  parameter int IDLE_MIN = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            s,
  input  logic            cfg_nine,
  input  logic            cfg_par_en,
  input  logic            cfg_par_odd,
  output logic            done,
  output logic [DATA_W:0] frame,
  output logic            fe,
  output logic            pe
);
  localparam int PH_W   = $clog2(OVS);
  localparam int SLOT_W = $clog2(DATA_W + 3);
  localparam int HC_W   = $clog2(IDLE_MIN + 1);
  localparam logic [PH_W-1:0] PH_S1   = PH_W'(OVS / 8);
  localparam logic [PH_W-1:0] PH_S2   = PH_W'(OVS / 4);
  localparam logic [PH_W-1:0] PH_S3   = PH_W'(3 * OVS / 8);
  localparam logic [PH_W-1:0] PH_D1   = PH_W'(OVS / 2 - 1);
  localparam logic [PH_W-1:0] PH_D2   = PH_W'(OVS / 2);
  localparam logic [PH_W-1:0] PH_D3   = PH_W'(OVS / 2 + 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVS - 1);
  localparam logic [HC_W-1:0] HC_ARM  = HC_W'(IDLE_MIN);

  urx_state_e        st;
  logic [PH_W-1:0]   ph;
  logic [SLOT_W-1:0] slot;
  logic [HC_W-1:0]   hc;
  logic              va, vb, par_rx;
  logic [DATA_W:0]   shreg;
  logic              maj;
  logic [SLOT_W-1:0] n_data, stop_slot;
  logic              is_par, is_stop, cap_a, cap_b, decide, par_calc;

  urx_vote3 u_vote (.a(va), .b(vb), .c(s), .m(maj));

  always_comb begin
    n_data    = cfg_nine ? SLOT_W'(DATA_W + 1) : SLOT_W'(DATA_W);
    stop_slot = n_data + SLOT_W'(cfg_par_en);
    is_par    = cfg_par_en && (slot == n_data);
    is_stop   = (slot == stop_slot);
    cap_a     = (st == URX_START) ? (ph == PH_S1) : (ph == PH_D1);
    cap_b     = (st == URX_START) ? (ph == PH_S2) : (ph == PH_D2);
    decide    = tick && (((st == URX_START) && (ph == PH_S3)) ||
                         ((st == URX_BITS) && (ph == PH_D3)));
    done      = decide && (st == URX_BITS) && is_stop;
    par_calc  = (^shreg[DATA_W-1:0]) ^ (cfg_nine & shreg[DATA_W]) ^ cfg_par_odd;
    fe        = !maj;
    pe        = cfg_par_en && (par_rx != par_calc);
    frame     = {cfg_nine & shreg[DATA_W], shreg[DATA_W-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= URX_HUNT;
      ph     <= '0;
      slot   <= '0;
      hc     <= '0;
      va     <= 1'b1;
      vb     <= 1'b1;
      par_rx <= 1'b0;
      shreg  <= '0;
    end else if (tick) begin
      unique case (st)
        URX_HUNT: begin
          if (s) begin
            if (hc != HC_ARM) hc <= hc + 1'b1;
          end else if (hc == HC_ARM) begin
            st <= URX_START;
            ph <= PH_W'(1);
            hc <= '0;
          end else begin
            hc <= '0;
          end
        end
        URX_START, URX_BITS: begin
          if (cap_a) va <= s;
          if (cap_b) vb <= s;
          if (ph == PH_LAST) ph <= '0;
          else               ph <= ph + 1'b1;
          if (st == URX_START) begin
            if (decide && maj) begin
              st <= URX_HUNT;
              hc <= '0;
            end else if (ph == PH_LAST) begin
              st   <= URX_BITS;
              slot <= '0;
            end
          end else begin
            if (decide) begin
              if (slot < n_data)  shreg[slot] <= maj;
              else if (is_par)    par_rx <= maj;
              else begin
                st <= URX_HUNT;
                hc <= '0;
              end
            end
            if (ph == PH_LAST) slot <= slot + 1'b1;
          end
        end
        default: st <= URX_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/urx_hold.sv
module urx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [DATA_W:0]   frame,
  input  logic              fe,
  input  logic              pe,
  input  logic              ready,
  output logic              valid,
  output logic [DATA_W-1:0] data,
  output logic              bit8,
  output logic              frame_err,
  output logic              par_err,
  output logic              overrun
);
  logic accept, drop, xfer;

  assign xfer   = valid && ready;
  assign accept = done && (!valid || ready);
  assign drop   = done && valid && !ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid     <= 1'b0;
      data      <= '0;
      bit8      <= 1'b0;
      frame_err <= 1'b0;
      par_err   <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      if (accept) begin
        valid     <= 1'b1;
        data      <= frame[DATA_W-1:0];
        bit8      <= frame[DATA_W];
        frame_err <= fe;
        par_err   <= pe;
      end else if (xfer) begin
        valid     <= 1'b0;
        frame_err <= 1'b0;
        par_err   <= 1'b0;
      end
      if (drop)      overrun <= 1'b1;
      else if (xfer) overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/ovs_uart_rx.sv
module ovs_uart_rx #(
  parameter int OVS         = 16,
  parameter int DATA_W      = 8,
  parameter int IDLE_MIN    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_16x,
  input  logic              rx_line,
  input  logic              cfg_nine,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_bit8,
  output logic              rd_frame_err,
  output logic              rd_par_err,
  output logic              rd_overrun
);
  logic            rx_s, f_done, f_fe, f_pe;
  logic [DATA_W:0] f_frame;

  urx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rx_line), .q(rx_s)
  );

  urx_framer #(.OVS(OVS), .DATA_W(DATA_W), .IDLE_MIN(IDLE_MIN)) u_framer (
    .clk(clk), .rst_n(rst_n), .tick(tick_16x), .s(rx_s),
    .cfg_nine(cfg_nine), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .done(f_done), .frame(f_frame), .fe(f_fe), .pe(f_pe)
  );

  urx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .done(f_done), .frame(f_frame),
    .fe(f_fe), .pe(f_pe), .ready(rd_ready), .valid(rd_valid),
    .data(rd_data), .bit8(rd_bit8), .frame_err(rd_frame_err),
    .par_err(rd_par_err), .overrun(rd_overrun)
  );
endmodule

// File: rtl/urx_checker.sv
module urx_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_16x,
  input logic              cfg_nine,
  input logic              rd_ready,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_bit8,
  input logic              rd_frame_err,
  input logic              rd_par_err,
  input logic              rd_overrun
);
  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid); // R6
  AST_HOLD_CONTENT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> $stable(rd_data) && $stable(rd_bit8) &&
    $stable(rd_frame_err) && $stable(rd_par_err)); // R6
  AST_VALID_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> $past(tick_16x)); // R6
  AST_FLAGS_NEED_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> !rd_frame_err && !rd_par_err && !rd_overrun); // R7
  AST_OVR_WHILE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_overrun) |-> rd_valid && $past(rd_valid)); // R9
  AST_XFER_CLEARS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_ready |=> !rd_overrun); // R10
  AST_BIT8_LOW_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) && !$past(cfg_nine) |-> !rd_bit8); // R5
endmodule

bind ovs_uart_rx urx_checker #(.DATA_W(DATA_W)) u_urx_checker (
  .clk(clk), .rst_n(rst_n), .tick_16x(tick_16x), .cfg_nine(cfg_nine),
  .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
  .rd_bit8(rd_bit8), .rd_frame_err(rd_frame_err), .rd_par_err(rd_par_err),
  .rd_overrun(rd_overrun)
);

// File: tb/ovs_uart_rx_bench.sv
module ovs_uart_rx_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, rx = 1'b1;
  logic nine = 1'b0, par_en = 1'b0, par_odd = 1'b0, ready = 1'b0;
  logic rd_valid, rd_bit8, rd_fe, rd_pe, rd_ovr;
  logic [7:0] rd_data;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;
  int   m_slot = -1;
  logic [15:0] m_mask = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ovs_uart_rx u_ovs_uart_rx (
    .clk(clk), .rst_n(rst_n), .tick_16x(tick), .rx_line(rx),
    .cfg_nine(nine), .cfg_par_en(par_en), .cfg_par_odd(par_odd),
    .rd_ready(ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_bit8(rd_bit8), .rd_frame_err(rd_fe), .rd_par_err(rd_pe),
    .rd_overrun(rd_ovr)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one sample period of four clocks, tick in the last one
  task automatic sample(input logic v);
    rx = v;
    repeat (3) @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic send_bit(input logic v, input int slot_id);
    for (int k = 0; k < 16; k++)
      sample(v ^ ((slot_id == m_slot) ? m_mask[k] : 1'b0));
  endtask

  task automatic send_frame(input logic [8:0] d, input int idle,
                            input logic par_flip, input logic stop_v);
    int nb;
    logic p;
    nb = nine ? 9 : 8;
    p = par_odd ^ par_flip;
    for (int i = 0; i < idle; i++) sample(1'b1);
    send_bit(1'b0, 0);
    for (int i = 0; i < nb; i++) begin
      send_bit(d[i], i + 1);
      p = p ^ d[i];
    end
    if (par_en) send_bit(p, 20);
    send_bit(stop_v, 21);
    m_slot = -1;
  endtask

  task automatic expect_char(input string req, input int dat, input int b8,
                             input int fe, input int pe, input int ovr);
    check({req, " valid"}, rd_valid, 1);
    check({req, " data"}, rd_data, dat);
    check({req, " bit8"}, rd_bit8, b8);
    check({req, " frame_err"}, rd_fe, fe);
    check({req, " par_err"}, rd_pe, pe);
    check({req, " overrun"}, rd_ovr, ovr);
  endtask

  task automatic do_read();
    ready = 1'b1;
    @(negedge clk);
    ready = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1 valid", rd_valid, 0);
    check("R1 flags", {rd_fe, rd_pe, rd_ovr}, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_unarmed_edge();
    sample(1'b1); sample(1'b1);
    for (int i = 0; i < 16; i++) sample(1'b0);
    for (int i = 0; i < 40; i++) sample(1'b1);
    check("R2 two idle samples do not arm", rd_valid, 0);
    send_frame(9'h05A, 3, 1'b0, 1'b1);
    expect_char("R2 three idle samples arm", 8'h5A, 0, 0, 0, 0);
    do_read();
    check("R10 read clears valid", rd_valid, 0);
  endtask

  task automatic t_start_vote();
    // samples 3 and 5 high, others low: vote rejects
    for (int i = 0; i < 4; i++) sample(1'b1);
    for (int k = 1; k <= 8; k++) sample((k == 3 || k == 5) ? 1'b1 : 1'b0);
    for (int i = 0; i < 40; i++) sample(1'b1);
    check("R3 glitch rejected", rd_valid, 0);
    // sample 3 high only: still a start bit
    m_slot = 0; m_mask = 16'h0004;
    send_frame(9'h02D, 4, 1'b0, 1'b1);
    expect_char("R3 accepted with one high vote", 8'h2D, 0, 0, 0, 0);
    do_read();
  endtask

  task automatic t_bit_vote();
    m_slot = 1; m_mask = 16'hFC7F;
    send_frame(9'h0A5, 4, 1'b0, 1'b1);
    expect_char("R4 outside samples ignored", 8'hA5, 0, 0, 0, 0);
    do_read();
    m_slot = 1; m_mask = 16'h0180;
    send_frame(9'h0A5, 4, 1'b0, 1'b1);
    expect_char("R4 two of three flip bit", 8'hA4, 0, 0, 0, 0);
    do_read();
    m_slot = 1; m_mask = 16'h0200;
    send_frame(9'h0A5, 4, 1'b0, 1'b1);
    expect_char("R4 single flip outvoted", 8'hA5, 0, 0, 0, 0);
    do_read();
  endtask

  task automatic t_nine_bit();
    nine = 1'b1;
    send_frame(9'h1C3, 4, 1'b0, 1'b1);
    expect_char("R5 nine-bit high", 8'hC3, 1, 0, 0, 0);
    do_read();
    send_frame(9'h081, 4, 1'b0, 1'b1);
    expect_char("R5 nine-bit low", 8'h81, 0, 0, 0, 0);
    do_read();
    nine = 1'b0;
    send_frame(9'h101, 4, 1'b0, 1'b1);
    expect_char("R5 eight-bit", 8'h01, 0, 0, 0, 0);
    repeat (50) @(negedge clk);
    expect_char("R6 held under back-pressure", 8'h01, 0, 0, 0, 0);
    do_read();
  endtask

  task automatic t_frame_err();
    send_frame(9'h03C, 4, 1'b0, 1'b0);
    expect_char("R7 low stop", 8'h3C, 0, 1, 0, 0);
    do_read();
    check("R10 flags cleared", {rd_fe, rd_pe, rd_ovr}, 0);
  endtask

  task automatic t_parity();
    par_en = 1'b1; par_odd = 1'b0;
    send_frame(9'h003, 4, 1'b0, 1'b1);
    expect_char("R8 even good", 8'h03, 0, 0, 0, 0);
    do_read();
    send_frame(9'h003, 4, 1'b1, 1'b1);
    expect_char("R8 even bad", 8'h03, 0, 0, 1, 0);
    do_read();
    par_odd = 1'b1;
    send_frame(9'h001, 4, 1'b0, 1'b1);
    expect_char("R8 odd good", 8'h01, 0, 0, 0, 0);
    do_read();
    send_frame(9'h001, 4, 1'b1, 1'b1);
    expect_char("R8 odd bad", 8'h01, 0, 0, 1, 0);
    do_read();
    par_en = 1'b0; par_odd = 1'b0;
  endtask

  task automatic t_overrun();
    send_frame(9'h011, 4, 1'b0, 1'b1);
    send_frame(9'h013, 4, 1'b0, 1'b0);
    expect_char("R9 first kept", 8'h11, 0, 0, 0, 1);
    do_read();
    check("R10 overrun cleared", rd_ovr, 0);
    check("R10 valid cleared", rd_valid, 0);
    send_frame(9'h077, 4, 1'b0, 1'b1);
    expect_char("R9 next after read", 8'h77, 0, 0, 0, 0);
    do_read();
  endtask

  initial begin
    t_reset();
    t_unarmed_edge();
    t_start_vote();
    t_bit_vote();
    t_nine_bit();
    t_frame_err();
    t_parity();
    t_overrun();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule